// File: doc/BRIEF.md
# Pipelined Late-Write Static RAM Core

This block is a synthesizable synchronous static RAM of 36-bit words with register-to-register read timing and late write. A cycle is accepted when the select input is high and the sleep input is low. A read returns its word from an output register two rising edges after its address. A write presents its address, write enable and lane mask on one edge, and its data on the following edge. Because the data arrives late, the block keeps one pending-write entry. That entry is committed to the storage array when the next write's data arrives or when a cycle carries no read. This means a long run of reads never stalls or loses a write.

A read that hits a write still in flight takes the newest bytes from the write pipeline, lane by lane. Back-to-back write-then-read sequences are therefore coherent. The data bus is split into an input, a registered output and an output-enable. The output-enable is gated without a clock by the output-enable input and by the sleep input.

Top module: `lwsram_core`

## Requirements
- R1: A word is four 9-bit lanes; lane i is bits [9i+8:9i] and `lane_we[i]`=1 lets a write update it, while a write with `lane_we[i]`=0 leaves lane i of the stored word unchanged.
- R2: A read accepted on edge k (`sel`=1, `wr`=0, `sleep`=0) drives the addressed word on `d_out` with `d_oe`=1 (when `oe`=1) from edge k+1 until edge k+2.
- R3: For a write accepted on edge k, the word stored is the value on `d_in` at edge k+1, not the value at edge k.
- R4: A read always returns the most recent write to its address in issue order, including a write accepted on the edge just before the read, whose data arrives on the read's own edge.
- R5: `oe`=0 forces `d_oe` low at once, without a clock edge, and raising `oe` again restores it within the same cycle.
- R6: While `sleep`=1 the block accepts no read or write, `d_oe` is low at once, and stored contents survive.
- R7: A cycle with `sel`=0 performs no array access, even with `wr`=1, and `d_oe` is low after the following edge.
- R8: A pending write is never lost: any number of reads to other addresses may follow it, and it is still returned afterwards.
- R9: After synchronous reset `d_oe` is low and no operation is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Synchronous cycle select, active high |
| wr | input | 1 | Write when 1, read when 0 (sampled with sel) |
| lane_we | input | 4 | Per-lane write enables, bit i guards bits [9i+8:9i] |
| addr | input | 10 | Word address |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Low-power request, blocks new cycles |
| d_in | input | 36 | Write data, one cycle after its address |
| d_out | output | 36 | Registered read data |
| d_oe | output | 1 | Output driver enable for d_out |

## Verification
The assertions assume that `rst` is held high for at least one edge at start-up. They also assume that `sleep`, `sel`, `wr` and `addr` change only between rising edges. Under these assumptions, the pending entry and the read pipeline follow the sampled controls edge by edge. The stimulus drives every control at the falling edge and changes `sleep` only while the clock is steady. Every read targets an address that was written earlier in the run, so no check depends on the power-up contents of the array. The only inputs toggled between edges are the asynchronous `oe` and `sleep`, and they are changed inside a settled high phase of the clock.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/lwsram_array.sv
module lwsram_array #(
  parameter int AW    = 10,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  logic [LANES-1:0]      wmask,
  input  logic [LANES*LW-1:0]   wdata,
  input  logic [AW-1:0]         raddr,
  output logic [LANES*LW-1:0]   rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int W     = LANES * LW;

  logic [W-1:0] mem [DEPTH];

  // byte-enable write port plus read-first registered read port
  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (we && wmask[i]) mem[waddr][i*LW +: LW] <= wdata[i*LW +: LW];
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lwsram_wbuf.sv
module lwsram_wbuf
  import lwsram_pkg::*;
#(
  parameter int AW    = 10,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  op_e                   op,
  input  logic [AW-1:0]         addr,
  input  logic [LANES-1:0]      lane_we,
  input  logic [LANES*LW-1:0]   d_in,
  output logic                  mem_we,
  output logic [AW-1:0]         mem_waddr,
  output logic [LANES-1:0]      mem_wmask,
  output logic [LANES*LW-1:0]   mem_wdata,
  output logic [LANES-1:0]      fwd_mask,
  output logic [LANES*LW-1:0]   fwd_data,
  output logic                  w1_valid,
  output logic                  p_valid
);
  localparam int W = LANES * LW;

  // stage 1: address seen, data due on next edge
  logic [AW-1:0]    w1_a;
  logic [LANES-1:0] w1_m;
  // pending entry: complete write not yet in the array
  logic [AW-1:0]    p_a;
  logic [LANES-1:0] p_m;
  logic [W-1:0]     p_d;

  // the write port is free unless a read holds it back; a new entry forces the old one out
  assign mem_we    = p_valid && (w1_valid || op != OP_READ);
  assign mem_waddr = p_a;
  assign mem_wmask = p_m;
  assign mem_wdata = p_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      w1_valid <= 1'b0;
      p_valid  <= 1'b0;
    end else begin
      w1_valid <= (op == OP_WRITE);
      if (op == OP_WRITE) begin
        w1_a <= addr;
        w1_m <= lane_we;
      end
      if (w1_valid) begin
        p_valid <= 1'b1;
        p_a     <= w1_a;
        p_m     <= w1_m;
        p_d     <= d_in;
      end else if (mem_we) begin
        p_valid <= 1'b0;
      end
    end
  end

  // lane-wise forwarding for a read on this edge: stage 1 is newer than the pending entry
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      logic hit_w1, hit_p;
      hit_w1 = w1_valid && (w1_a == addr) && w1_m[i];
      hit_p  = p_valid && (p_a == addr) && p_m[i];
      fwd_mask[i] = hit_w1 || hit_p;
      fwd_data[i*LW +: LW] = hit_w1 ? d_in[i*LW +: LW] : p_d[i*LW +: LW];
    end
  end

  // R3: a write whose address was taken becomes a pending entry on the data edge
  a_r3_data_edge: assert property (@(posedge clk) disable iff (rst)
    w1_valid |=> p_valid);

  // R8: a read that cannot commit keeps the pending entry intact
  a_r8_hold_on_read: assert property (@(posedge clk) disable iff (rst)
    (p_valid && !w1_valid && op == OP_READ) |=> (p_valid && $stable(p_a) && $stable(p_d)));
endmodule

// File: rtl/lwsram_rdpipe.sv
module lwsram_rdpipe #(
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_acc,
  input  logic [LANES-1:0]      fwd_mask,
  input  logic [LANES*LW-1:0]   fwd_data,
  input  logic [LANES*LW-1:0]   rdata,
  output logic [LANES*LW-1:0]   dq_q,
  output logic                  vld_q
);
  localparam int W = LANES * LW;

  logic             s1_v;
  logic [LANES-1:0] s1_fm;
  logic [W-1:0]     s1_fd;
  logic [W-1:0]     merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v  <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      s1_v  <= rd_acc;
      vld_q <= s1_v;
    end
    s1_fm <= fwd_mask;
    s1_fd <= fwd_data;
    if (s1_v) dq_q <= merged;
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign merged[g*LW +: LW] = s1_fm[g] ? s1_fd[g*LW +: LW] : rdata[g*LW +: LW];
    end
  endgenerate
endmodule

// File: rtl/lwsram_core.sv
module lwsram_core
  import lwsram_pkg::*;
#(
  parameter int AW    = 10,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sel,
  input  logic                  wr,
  input  logic [LANES-1:0]      lane_we,
  input  logic [AW-1:0]         addr,
  input  logic                  oe,
  input  logic                  sleep,
  input  logic [LANES*LW-1:0]   d_in,
  output logic [LANES*LW-1:0]   d_out,
  output logic                  d_oe
);
  localparam int W = LANES * LW;

  op_e              op;
  logic             acc;
  logic             mem_we;
  logic [AW-1:0]    mem_waddr;
  logic [LANES-1:0] mem_wmask;
  logic [W-1:0]     mem_wdata;
  logic [LANES-1:0] fwd_mask;
  logic [W-1:0]     fwd_data;
  logic [W-1:0]     rdata;
  logic             w1_valid;
  logic             p_valid;
  logic             rd_vld;

  assign acc = sel && !sleep;
  assign op  = !acc ? OP_IDLE : (wr ? OP_WRITE : OP_READ);

  lwsram_wbuf #(.AW(AW), .LANES(LANES), .LW(LW)) u_wbuf (
    .clk(clk), .rst(rst), .op(op), .addr(addr), .lane_we(lane_we), .d_in(d_in),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wmask(mem_wmask), .mem_wdata(mem_wdata),
    .fwd_mask(fwd_mask), .fwd_data(fwd_data), .w1_valid(w1_valid), .p_valid(p_valid)
  );

  lwsram_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wmask(mem_wmask), .wdata(mem_wdata),
    .raddr(addr), .rdata(rdata)
  );

  lwsram_rdpipe #(.LANES(LANES), .LW(LW)) u_rdpipe (
    .clk(clk), .rst(rst), .rd_acc(op == OP_READ), .fwd_mask(fwd_mask), .fwd_data(fwd_data),
    .rdata(rdata), .dq_q(d_out), .vld_q(rd_vld)
  );

  // output drivers gated without a clock
  assign d_oe = rd_vld && oe && !sleep;

  // R2: an accepted read reaches the output register after the second edge
  a_r2_read_latency: assert property (@(posedge clk) disable iff (rst)
    (sel && !wr && !sleep) |=> ##1 rd_vld);

  // R6: sleep admits no write into the pipeline
  a_r6_sleep_blocks: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !w1_valid);

  // R7: a deselected cycle leaves the drivers off after the following edge
  a_r7_desel_tristate: assert property (@(posedge clk) disable iff (rst)
    !sel |=> ##1 !d_oe);

  // R9: reset leaves no pending entry behind
  a_r9_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!p_valid && !w1_valid));
endmodule

// File: tb/sim_lwsram_core.sv
module sim_lwsram_core;
  localparam int AW = 10;
  localparam int W  = 36;

  typedef struct {
    int          due;
    logic [W-1:0] val;
    string       rq;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sel = 1'b0, wr = 1'b0, oe = 1'b1, sleep = 1'b0;
  logic [3:0]   lane_we = 4'h0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0] d_in = '0;
  logic [W-1:0] d_out;
  logic         d_oe;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [W-1:0] model [1 << AW];
  logic [W-1:0] carry_din = 36'h5A5A5A5A5;
  exp_t q[$];

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  lwsram_core u0 (
    .clk(clk), .rst(rst), .sel(sel), .wr(wr), .lane_we(lane_we), .addr(addr),
    .oe(oe), .sleep(sleep), .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
  );

  task automatic chk(input bit ok, input string rq, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", rq, act, exp, cyc);
    end
  endtask

  // driver: one bus cycle; pushes expected read results
  task automatic step(input bit s, input bit w, input logic [3:0] m, input logic [AW-1:0] a,
                      input logic [W-1:0] d, input bit o, input bit sl, input string rq);
    @(negedge clk);
    d_in = carry_din;
    carry_din = 36'h5A5A5A5A5;
    sel = s; wr = w; lane_we = m; addr = a; oe = o; sleep = sl;
    if (s && !sl) begin
      if (w) begin
        carry_din = d;
        for (int i = 0; i < 4; i++) if (m[i]) model[a][i*9 +: 9] = d[i*9 +: 9];
      end else begin
        q.push_back('{due: cyc + 2, val: model[a], rq: rq});
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 4'h0, '0, '0, 1, 0, "R7");
  endtask

  // monitor: compares outputs with the scoreboard away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (!rst) begin
        bit hit;
        bit en;
        hit = (q.size() > 0) && (q[0].due == cyc);
        en  = hit && oe && !sleep;
        chk(d_oe == en, hit ? q[0].rq : "R7", {35'b0, d_oe}, {35'b0, en});
        if (en) chk(d_out == q[0].val, q[0].rq, d_out, q[0].val);
        if (hit) void'(q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1 chk(d_oe == 1'b0, "R9", {35'b0, d_oe}, '0);

    // fill 16 words, full mask
    for (int i = 0; i < 16; i++)
      step(1, 1, 4'hF, AW'(i), 36'h123456789 ^ (W'(i) * 36'h111111111), 1, 0, "R3");
    idle(1);
    // back-to-back reads, R2
    for (int i = 0; i < 16; i++) step(1, 0, 4'h0, AW'(i), '0, 1, 0, "R2");
    idle(2);

    // R1: partial lanes, read right after (forwarded) and later (from array)
    step(1, 1, 4'b0101, 10'd3, 36'hABCDEF012, 1, 0, "R1");
    step(1, 0, 4'h0, 10'd3, '0, 1, 0, "R1");
    idle(2);
    step(1, 0, 4'h0, 10'd3, '0, 1, 0, "R1");
    idle(2);

    // R4: two writes to one address with different lanes, then read
    step(1, 1, 4'b0011, 10'd7, 36'h111111111, 1, 0, "R4");
    step(1, 1, 4'b0110, 10'd7, 36'h222222222, 1, 0, "R4");
    step(1, 0, 4'h0, 10'd7, '0, 1, 0, "R4");
    step(1, 1, 4'b1000, 10'd8, 36'hF00000000, 1, 0, "R4");
    step(1, 0, 4'h0, 10'd7, '0, 1, 0, "R4");
    step(1, 0, 4'h0, 10'd8, '0, 1, 0, "R4");
    idle(2);

    // R3: data taken one edge after the address, read back after an idle commit
    step(1, 1, 4'hF, 10'd9, 36'h0FEDCBA98, 1, 0, "R3");
    idle(2);
    step(1, 0, 4'h0, 10'd9, '0, 1, 0, "R3");
    idle(2);

    // R8: write then a long run of reads to other addresses
    step(1, 1, 4'hF, 10'd12, 36'h3C3C3C3C3, 1, 0, "R8");
    for (int i = 0; i < 20; i++) step(1, 0, 4'h0, AW'(i % 6), '0, 1, 0, "R8");
    step(1, 0, 4'h0, 10'd12, '0, 1, 0, "R8");
    idle(2);

    // R7: deselected write does nothing
    step(0, 1, 4'hF, 10'd5, 36'hDEADBEEF0, 1, 0, "R7");
    step(0, 0, 4'h0, '0, 36'hDEADBEEF0, 1, 0, "R7");
    step(1, 0, 4'h0, 10'd5, '0, 1, 0, "R7");
    idle(2);

    // R5: oe toggled inside a cycle while a read is on the output
    step(1, 0, 4'h0, 10'd4, '0, 1, 0, "R5");
    idle(1);
    @(posedge clk);
    #8 oe = 1'b0;
    #1 chk(d_oe == 1'b0, "R5", {35'b0, d_oe}, '0);
    oe = 1'b1;
    #0.5 chk(d_oe == 1'b1 && d_out == model[4], "R5", d_out, model[4]);
    idle(2);

    // R6: sleep drops the drivers at once, blocks cycles, keeps contents
    step(1, 0, 4'h0, 10'd2, '0, 1, 0, "R6");
    idle(1);
    @(posedge clk);
    #8 sleep = 1'b1;
    #1 chk(d_oe == 1'b0, "R6", {35'b0, d_oe}, '0);
    sleep = 1'b0;
    for (int i = 0; i < 3; i++) step(1, 0, 4'h0, 10'd2, '0, 1, 1, "R6");
    step(1, 1, 4'hF, 10'd2, 36'h777777777, 1, 1, "R6");
    step(1, 1, 4'hF, 10'd6, 36'h888888888, 1, 1, "R6");
    step(0, 0, 4'h0, '0, 36'h888888888, 1, 1, "R6");
    step(1, 0, 4'h0, 10'd2, '0, 1, 0, "R6");
    step(1, 0, 4'h0, 10'd6, '0, 1, 0, "R6");
    step(1, 0, 4'h0, 10'd3, '0, 1, 0, "R6");
    idle(4);

    chk(q.size() == 0, "R2", W'(q.size()), '0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule